// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block models the target side of a small two-wire serial EEPROM that holds 128 or 256 bytes. A host toggles the clock and data lines through a software-written register, and this model receives the resulting levels as already-synchronous inputs sampled on the system clock. It returns the level that the target would put on the shared data line. Input levels that do not change from one system clock to the next are not treated as new events.

A transaction is a fixed sequence of ticks. A start condition is followed by eight command bits and then an acknowledge. Eight address bits come next, then a second acknowledge. The address phase of a read transaction also shifts out, MSB first, the byte that was latched at the end of the previous address phase. A random read is therefore a write-command transaction that sets the address, followed by a read-command transaction. Memory contents are computed from two parameters, so the model has no storage array.

Top module: `i2c_prom_responder`

## Requirements
- R1: After reset the returned line `sda_o` is 1, no acknowledge is pending, and the bit counter is idle (0).
- R2: A falling `sda_i` while `scl_i` was high and stays high is a start. It sets the bit counter to 1 and clears the command register, including in the middle of a transaction.
- R3: While the counter is idle and no acknowledge is pending, rising clock edges are ignored. No bit is taken and no acknowledge is produced.
- R4: A bit is taken only on a rising `scl_i` where `sda_i` keeps the level it had before the edge. An edge on which both lines change is ignored.
- R5: After eight accepted command bits an acknowledge is pending. The next rising `scl_i` drives `sda_o` to 0 whatever the host drives, clears the pending flag and takes no bit.
- R6: The next eight accepted bits shift MSB first into the address register. After the eighth bit, the byte at that address is latched into the shift register, an acknowledge becomes pending (driven 0 on the next rising edge), and the counter returns to idle.
- R7: When bit 0 of the command is 1 (read), each accepted rising edge of the address phase drives `sda_o` with the MSB of the shift register, which then shifts left by one.
- R8: When bit 0 of the command is 0 (write), `sda_o` follows `sda_i` throughout the address phase.
- R9: Outside a forced acknowledge or read bit, every change of the input levels makes `sda_o` follow `sda_i`. `sda_o` holds while both inputs stay unchanged.
- R10: A rising `sda_i` while `scl_i` was high and stays high is a stop. It leaves the bit counter and the pending acknowledge unchanged.
- R11: The byte at index i is (i × `ROM_STEP` + `ROM_SEED`) mod 256, with defaults 29 and 0x5A. The index is the address modulo `DEPTH` (128 or 256), so upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which the line levels are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Clock line level written by the host |
| sda_i | input | 1 | Data line level written by the host |
| sda_o | output | 1 | Data line level returned by the responder |

## Verification
The bench aims at an ignored edge where both lines move at once. A design that counted that edge would acknowledge one bit early, pulling the eighth command bit low. It restarts a command in mid-byte and issues a stop partway through a byte. A counter that failed to reset on the restart, or that was cleared by the stop, would move the acknowledge off its slot. It also reads through two instances with 256 and 128 bytes at an address above 127. This exposes a missing wrap, and it exposes a read that returned the byte of the current address phase instead of the byte latched in the preceding one.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int TICK_W = 5;
    localparam int BYTE_W = 8;

    // counter value reached after the last command bit and after the last address bit
    localparam logic [TICK_W-1:0] TICK_CMD_END  = TICK_W'(9);
    localparam logic [TICK_W-1:0] TICK_ADDR_END = TICK_W'(17);

    typedef enum logic [2:0] {
        COND_NONE,   // no input change this cycle
        COND_START,  // data fell with clock held high
        COND_STOP,   // data rose with clock held high
        COND_RISE,   // clock rose
        COND_OTHER   // any other change
    } cond_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] shreg;
        logic              ack;
        logic              drv;
    } seq_t;

endpackage

// File: rtl/i2cp_line_monitor.sv
module i2cp_line_monitor
    import i2cp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_i,
    input  logic  sda_i,
    output cond_e cond_o,
    output logic  steady_o,
    output logic  evt_o
);

    lines_t lv_d, lv_q;

    always_comb begin
        lv_d = '{scl: scl_i, sda: sda_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            lv_q <= lv_d;
        end
    end

    always_comb begin
        evt_o    = (lv_d != lv_q);
        steady_o = (lv_d.sda == lv_q.sda);
        if (!evt_o) begin
            cond_o = COND_NONE;
        end else if (lv_q.scl && lv_d.scl && !steady_o) begin
            cond_o = lv_d.sda ? COND_STOP : COND_START;
        end else if (!lv_q.scl && lv_d.scl) begin
            cond_o = COND_RISE;
        end else begin
            cond_o = COND_OTHER;
        end
    end

endmodule

// File: rtl/i2cp_rom.sv
module i2cp_rom #(
    parameter int DEPTH    = 256,
    parameter int ROM_SEED = 90,
    parameter int ROM_STEP = 29,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       data_o
);

    // R11: contents are an affine function of the index, truncated to a byte
    always_comb begin
        data_o = 8'(idx_i) * 8'(ROM_STEP) + 8'(ROM_SEED);
    end

endmodule

// File: rtl/i2cp_sequencer.sv
module i2cp_sequencer
    import i2cp_pkg::*;
#(
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cond_e             cond_i,
    input  logic              steady_i,
    input  logic              evt_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] rom_data_i,
    output logic [IDX_W-1:0]  rom_idx_o,
    output logic              drv_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o
);

    seq_t              st_d, st_q;
    logic [BYTE_W-1:0] addr_nx;

    always_comb begin
        addr_nx   = {st_q.addr[BYTE_W-2:0], sda_i};
        rom_idx_o = addr_nx[IDX_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (evt_i) begin
            st_d.drv = sda_i;  // R9: default pass-through on any change
            if (cond_i == COND_START) begin
                st_d.tick = TICK_W'(1);  // R2
                st_d.cmd  = '0;
            end else if (cond_i == COND_STOP) begin
                st_d.tick = st_q.tick;   // R10: nothing changes
            end else if (st_q.tick == '0 && !st_q.ack) begin
                st_d.tick = st_q.tick;   // R3: waiting for a start
            end else if (cond_i == COND_RISE) begin
                if (st_q.ack) begin
                    st_d.drv = 1'b0;     // R5 / R6: acknowledge slot
                    st_d.ack = 1'b0;
                end else if (steady_i) begin
                    if (st_q.tick < TICK_CMD_END) begin
                        st_d.cmd  = {st_q.cmd[BYTE_W-2:0], sda_i};
                        st_d.tick = st_q.tick + TICK_W'(1);
                        if (st_d.tick == TICK_CMD_END) begin
                            st_d.ack = 1'b1;
                        end
                    end else begin
                        if (st_q.cmd[0]) begin
                            st_d.drv = st_q.shreg[BYTE_W-1];  // R7
                        end
                        st_d.addr  = addr_nx;
                        st_d.shreg = {st_q.shreg[BYTE_W-2:0], 1'b0};
                        st_d.tick  = st_q.tick + TICK_W'(1);
                        if (st_d.tick == TICK_ADDR_END) begin
                            st_d.shreg = rom_data_i;  // R6
                            st_d.ack   = 1'b1;
                            st_d.tick  = '0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{tick: '0, cmd: '0, addr: '0, shreg: '0, ack: 1'b0, drv: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        drv_o  = st_q.drv;
        tick_o = st_q.tick;
        ack_o  = st_q.ack;
    end

endmodule

// File: rtl/i2c_prom_responder.sv
module i2c_prom_responder
    import i2cp_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int ROM_SEED = 90,
    parameter int ROM_STEP = 29,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);

    cond_e             cond;
    logic              steady;
    logic              evt;
    logic [IDX_W-1:0]  rom_idx;
    logic [BYTE_W-1:0] rom_data;
    logic [TICK_W-1:0] tick;
    logic              ack_pend;

    i2cp_line_monitor u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .cond_o   (cond),
        .steady_o (steady),
        .evt_o    (evt)
    );

    i2cp_rom #(
        .DEPTH    (DEPTH),
        .ROM_SEED (ROM_SEED),
        .ROM_STEP (ROM_STEP)
    ) u_rom (
        .idx_i  (rom_idx),
        .data_o (rom_data)
    );

    i2cp_sequencer #(
        .DEPTH (DEPTH)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond),
        .steady_i   (steady),
        .evt_i      (evt),
        .sda_i      (sda_i),
        .rom_data_i (rom_data),
        .rom_idx_o  (rom_idx),
        .drv_o      (sda_o),
        .tick_o     (tick),
        .ack_o      (ack_pend)
    );

endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker
    import i2cp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_o,
    input cond_e             cond,
    input logic              evt,
    input logic [TICK_W-1:0] tick,
    input logic              ack_pend
);

    p_start_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_START) |=> (tick == TICK_W'(1)));

    p_idle_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick == '0 && !ack_pend && cond != COND_START) |=> (tick == '0 && !ack_pend));

    p_ack_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pend && cond == COND_RISE) |=> (!sda_o && !ack_pend));

    p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick < TICK_ADDR_END));

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> ($stable(sda_o) && $stable(tick) && $stable(ack_pend)));

    p_stop_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_STOP) |=> ($stable(tick) && $stable(ack_pend)));

endmodule

bind i2c_prom_responder i2cp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_o    (sda_o),
    .cond     (cond),
    .evt      (evt),
    .tick     (tick),
    .ack_pend (ack_pend)
);

// File: tb/tb_i2c_prom_responder.sv
module tb_i2c_prom_responder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_o;
    logic sda_o_s;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    i2c_prom_responder dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o)
    );

    i2c_prom_responder #(.DEPTH(128)) dut_small (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o_s)
    );

    function automatic logic [7:0] rom_byte(int a, int depth);
        return 8'((((a % depth) * 29) + 90) % 256);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive(logic c, logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_start();
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic send_byte(logic [7:0] v, output logic [7:0] rx, output logic [7:0] rxs);
        for (int i = 7; i >= 0; i--) begin
            drive(1'b0, v[i]);
            drive(1'b1, v[i]);
            rx[i]  = sda_o;
            rxs[i] = sda_o_s;
            drive(1'b0, v[i]);
        end
    endtask

    task automatic ack_clk(string req);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        check(req, {7'd0, sda_o}, 8'h00);
        check(req, {7'd0, sda_o_s}, 8'h00);
        drive(1'b0, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 reset level", {7'd0, sda_o}, 8'h01);
        check("R1 reset level small", {7'd0, sda_o_s}, 8'h01);
    endtask

    task automatic t_idle_ignore();
        logic [7:0] rx, rxs;
        drive(1'b0, 1'b0);
        check("R9 follow low", {7'd0, sda_o}, 8'h00);
        repeat (6) @(negedge clk);
        check("R9 hold unchanged", {7'd0, sda_o}, 8'h00);
        send_byte(8'hFF, rx, rxs);
        check("R3 no bits before start", rx, 8'hFF);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        check("R3 no ack before start", {7'd0, sda_o}, 8'h01);
        drive(1'b0, 1'b1);
    endtask

    task automatic t_set_addr(logic [7:0] a);
        logic [7:0] rx, rxs;
        do_start();
        send_byte(8'hA0, rx, rxs);
        check("R9 command echo", rx, 8'hA0);
        ack_clk("R5 command ack");
        send_byte(a, rx, rxs);
        check("R8 write address echo", rx, a);
        ack_clk("R6 address ack");
    endtask

    task automatic t_read(logic [7:0] exp, logic [7:0] exp_s);
        logic [7:0] rx, rxs;
        do_start();
        send_byte(8'hA1, rx, rxs);
        ack_clk("R5 read command ack");
        send_byte(8'hFF, rx, rxs);
        check("R7 read byte", rx, exp);
        check("R11 read byte small depth", rxs, exp_s);
        ack_clk("R6 read address ack");
    endtask

    task automatic t_glitch();
        logic [7:0] rx, rxs;
        do_start();
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        send_byte(8'hA0 | 8'h01, rx, rxs);
        check("R4 moving-data edge ignored", rx, 8'hA1);
        ack_clk("R4 ack after eight bits");
        send_byte(8'h10, rx, rxs);
        ack_clk("R6 address ack after glitch");
    endtask

    task automatic t_restart();
        logic [7:0] rx, rxs;
        do_start();
        send_byte(8'hA0, rx, rxs);
        ack_clk("R5 ack before restart");
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        do_start();
        send_byte(8'hA1, rx, rxs);
        check("R2 restart clears count", rx, 8'hA1);
        ack_clk("R2 ack after restart");
        send_byte(8'h22, rx, rxs);
        ack_clk("R6 ack after restart address");
    endtask

    task automatic t_stop();
        logic [7:0] rx, rxs;
        do_start();
        send_byte(8'hFF, rx, rxs);
        ack_clk("R5 ack before stop test");
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 1'b0);
            drive(1'b1, 1'b0);
            drive(1'b0, 1'b0);
        end
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        check("R9 follow after stop", {7'd0, sda_o}, 8'h01);
        drive(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, 1'b1);
            drive(1'b1, 1'b1);
            drive(1'b0, 1'b1);
        end
        ack_clk("R10 stop keeps count");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_set_addr(8'h3C);
        t_read(rom_byte(8'h3C, 256), rom_byte(8'h3C, 128));
        t_read(rom_byte(8'hFF, 256), rom_byte(8'hFF, 128));
        t_set_addr(8'h85);
        t_read(rom_byte(8'h85, 256), rom_byte(8'h05, 128));
        t_glitch();
        t_restart();
        t_stop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule